// File: doc/BRIEF.md
# Duty-Cycled Infrared Interval Capture

This block supervises a digital infrared receiver line and works from a slow tick (one clock-wide pulse per 32 kHz period) while running on the fast system clock. When enabled, it powers the external sensor for a programmable detection window and counts edges on the line. If the window closes with too few edges, the sensor is switched off for a programmable sleep interval and a fresh window follows. Once enough edges arrive, the block enters capture and stores, for every later edge, the number of ticks since the edge before it together with the new line level.

A frame ends when the line stays quiet for a programmable number of ticks. At that point a done flag is raised, sensor power is dropped and capture halts until software rearms the block with the restart control or the soft reset. Software then fetches the stored words through an address and read-enable port and reads the count of valid words. A continuous mode keeps the sensor powered and replaces each failed window at once with a new window, with no sleep interval in between.

Top module: `irc_capture_top`

## Requirements
- R1: While `det_en_i` is low the block is idle with `sensor_pwr_o` and `frame_done_o` low. After `det_en_i` goes high, `sensor_pwr_o` is high from the next clock, because a detection window has started.
- R2: A detection window lasts `on_len_i` ticks. If it closes before the edge threshold is met, and continuous mode is off, `sensor_pwr_o` stays low for `off_len_i` ticks and then a new window starts with power high.
- R3: Capture begins on the edge that brings the edge count of the current window up to `edge_thr_i`, where a threshold of 0 acts as 1. At that moment `entry_cnt_o` is cleared to 0, and the qualifying edge itself is not stored.
- R4: Each later edge during capture writes the word at address `entry_cnt_o` and then increments `entry_cnt_o`. The word holds the line level after the edge in bit 15. Bits 14:0 hold the number of ticks from the previous edge's clock up to, but not including, this edge's clock, saturating at 0x7FFF.
- R5: A frame ends on the tick that brings the tick count since the last edge to `idle_len_i`, where the tick in the edge's own clock counts as the first. At that point `frame_done_o` goes high and `sensor_pwr_o` goes low. Edges arriving after the frame end change neither `entry_cnt_o` nor the stored words.
- R6: An edge in the same clock as the frame-ending tick takes priority. That edge is stored, and the frame continues.
- R7: With `cont_mode_i` high, `sensor_pwr_o` never drops while windows expire without qualifying. Each failed window is followed at once by a new one.
- R8: Once 128 words have been stored, further edges are not written and `entry_cnt_o` stays at 128. The frame still ends on the idle timeout.
- R9: A read with `rd_en_i` high returns the word at `rd_addr_i` on `rd_data_o` one clock later. While `rd_en_i` is low, `rd_data_o` holds its value.
- R10: A pulse on `restart_i` while enabled starts a fresh detection window from any state and clears `frame_done_o`. It leaves `entry_cnt_o` unchanged until a new capture qualifies.
- R11: `soft_rst_i` takes priority over `restart_i`. During a soft reset the block is idle with `entry_cnt_o` at 0 and `frame_done_o` and `sensor_pwr_o` low. After it is released, an enabled block starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse per 32 kHz period |
| det_en_i | input | 1 | Detection enable |
| cont_mode_i | input | 1 | Continuous mode, no power cycling |
| restart_i | input | 1 | Start a fresh detection window |
| soft_rst_i | input | 1 | Clear capture state and counters |
| on_len_i | input | 12 | Detection window length in ticks |
| off_len_i | input | 17 | Sleep interval length in ticks |
| edge_thr_i | input | 7 | Minimum edges needed within a window |
| idle_len_i | input | 15 | Quiet ticks that end a frame |
| ir_i | input | 1 | Asynchronous receiver line |
| rd_addr_i | input | 7 | Read address of the interval memory |
| rd_en_i | input | 1 | Read enable |
| sensor_pwr_o | output | 1 | External sensor power enable |
| frame_done_o | output | 1 | Frame captured, capture halted |
| rd_data_o | output | 16 | Read word: level in bit 15, interval in bits 14:0 |
| entry_cnt_o | output | 8 | Valid words stored for the last frame |

## Verification
During capture, an edge and the tick that would end the frame can fall in the same clock. The bench provokes this by aligning every edge with a tick and spacing two edges one tick fewer than the idle length, so that the edge arrives exactly on the timeout tick. It judges the result by reading back the stored word (the full gap, stored) and by checking that the frame goes on to end only later. A companion case spaces the edges by the full idle length and expects the late edge to be absent and the count to be unchanged.

// File: rtl/irc_pkg.sv
package irc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ON   = 3'd1,
        ST_OFF  = 3'd2,
        ST_CAPT = 3'd3,
        ST_DONE = 3'd4
    } irc_state_e;

endpackage

// File: rtl/irc_sync.sv
// Two-flop synchronizer for the receiver line plus an edge pulse.
module irc_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic level_o,
    output logic edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = line_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign level_o = q.s2;
    assign edge_o  = q.s2 ^ q.s3;
endmodule

// File: rtl/irc_mem.sv
// Interval store: one write port, registered read port.
module irc_mem #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) store_q[wr_addr_i] <= wr_data_i;
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) rd_d = store_q[rd_addr_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/irc_ctrl.sv
// Power-cycling, qualification and interval capture sequencer.
module irc_ctrl
    import irc_pkg::*;
#(
    parameter int ON_W   = 12,
    parameter int OFF_W  = 17,
    parameter int THR_W  = 7,
    parameter int IDLE_W = 15,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              det_en_i,
    input  logic              cont_mode_i,
    input  logic              restart_i,
    input  logic              soft_rst_i,
    input  logic [ON_W-1:0]   on_len_i,
    input  logic [OFF_W-1:0]  off_len_i,
    input  logic [THR_W-1:0]  edge_thr_i,
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              edge_i,
    input  logic              level_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              sensor_pwr_o,
    output logic              frame_done_o,
    output logic [ADDR_W:0]   entry_cnt_o,
    output irc_state_e        state_o
);
    localparam int TMR_W   = (ON_W > OFF_W) ? ON_W : OFF_W;
    localparam int TC_W    = TMR_W + 1;
    localparam int IVL_W   = DATA_W - 1;
    localparam int IC_W    = ((IDLE_W > IVL_W) ? IDLE_W : IVL_W) + 1;
    localparam int CNT_W   = ADDR_W + 1;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam logic [IVL_W-1:0] IVL_MAX = '1;

    typedef struct packed {
        irc_state_e        st;
        logic [TMR_W-1:0]  tmr;
        logic [THR_W-1:0]  ecnt;
        logic [IVL_W-1:0]  ivl;
        logic [CNT_W-1:0]  cnt;
    } ctrl_t;

    ctrl_t d, q;

    logic [TC_W-1:0]  tmr_inc;
    logic [THR_W:0]   ecnt_inc;
    logic [THR_W-1:0] thr_eff;
    logic [IVL_W-1:0] ivl_inc;
    logic [IVL_W-1:0] ivl_start;
    logic             on_over, off_over, idle_hit, qualify;

    always_comb begin
        d        = q;
        wr_en_o  = 1'b0;
        tmr_inc  = {1'b0, q.tmr} + TC_W'(1);
        ecnt_inc = {1'b0, q.ecnt} + (THR_W+1)'(1);
        thr_eff  = (edge_thr_i == '0) ? THR_W'(1) : edge_thr_i;
        qualify  = ecnt_inc >= {1'b0, thr_eff};
        on_over  = tmr_inc >= TC_W'(on_len_i);
        off_over = tmr_inc >= TC_W'(off_len_i);
        idle_hit = (IC_W'(q.ivl) + IC_W'(1)) >= IC_W'(idle_len_i);
        ivl_inc  = (q.ivl == IVL_MAX) ? q.ivl : q.ivl + IVL_W'(1);
        // the tick of the edge's own clock belongs to the new interval
        ivl_start = tick_i ? IVL_W'(1) : '0;

        case (q.st)
            ST_IDLE: begin
                if (det_en_i) begin
                    d.st = ST_ON; d.tmr = '0; d.ecnt = '0;
                end
            end
            ST_ON: begin
                if (edge_i && qualify) begin
                    d.st = ST_CAPT; d.cnt = '0; d.ivl = ivl_start;
                end else begin
                    if (edge_i) d.ecnt = ecnt_inc[THR_W-1:0];
                    if (tick_i) begin
                        if (on_over) begin
                            d.st   = cont_mode_i ? ST_ON : ST_OFF;
                            d.tmr  = '0;
                            d.ecnt = '0;
                        end else begin
                            d.tmr = tmr_inc[TMR_W-1:0];
                        end
                    end
                end
            end
            ST_OFF: begin
                if (cont_mode_i || (tick_i && off_over)) begin
                    d.st = ST_ON; d.tmr = '0; d.ecnt = '0;
                end else if (tick_i) begin
                    d.tmr = tmr_inc[TMR_W-1:0];
                end
            end
            ST_CAPT: begin
                if (edge_i) begin
                    if (q.cnt < CNT_W'(DEPTH)) begin
                        wr_en_o = 1'b1;
                        d.cnt   = q.cnt + CNT_W'(1);
                    end
                    d.ivl = ivl_start;
                end else if (tick_i) begin
                    if (idle_hit) d.st  = ST_DONE;
                    else          d.ivl = ivl_inc;
                end
            end
            ST_DONE: ;
            default: d.st = ST_IDLE;
        endcase

        if (restart_i) begin
            d.st = ST_ON; d.tmr = '0; d.ecnt = '0; d.cnt = q.cnt;
            wr_en_o = 1'b0;
        end
        if (!det_en_i) begin
            d.st = ST_IDLE; d.cnt = q.cnt;
            wr_en_o = 1'b0;
        end
        if (soft_rst_i) begin
            d = '0;
            wr_en_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign wr_addr_o    = q.cnt[ADDR_W-1:0];
    assign wr_data_o    = {level_i, q.ivl};
    assign sensor_pwr_o = (q.st == ST_ON) || (q.st == ST_CAPT);
    assign frame_done_o = (q.st == ST_DONE);
    assign entry_cnt_o  = q.cnt;
    assign state_o      = q.st;
endmodule

// File: rtl/irc_capture_top.sv
module irc_capture_top #(
    parameter int ON_W   = 12,
    parameter int OFF_W  = 17,
    parameter int THR_W  = 7,
    parameter int IDLE_W = 15,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              det_en_i,
    input  logic              cont_mode_i,
    input  logic              restart_i,
    input  logic              soft_rst_i,
    input  logic [ON_W-1:0]   on_len_i,
    input  logic [OFF_W-1:0]  off_len_i,
    input  logic [THR_W-1:0]  edge_thr_i,
    input  logic [IDLE_W-1:0] idle_len_i,
    input  logic              ir_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_en_i,
    output logic              sensor_pwr_o,
    output logic              frame_done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W:0]   entry_cnt_o
);
    logic              line_lvl, line_edge;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    irc_pkg::irc_state_e ctrl_st;

    irc_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_i  (ir_i),
        .level_o (line_lvl),
        .edge_o  (line_edge)
    );

    irc_ctrl #(
        .ON_W(ON_W), .OFF_W(OFF_W), .THR_W(THR_W),
        .IDLE_W(IDLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .det_en_i     (det_en_i),
        .cont_mode_i  (cont_mode_i),
        .restart_i    (restart_i),
        .soft_rst_i   (soft_rst_i),
        .on_len_i     (on_len_i),
        .off_len_i    (off_len_i),
        .edge_thr_i   (edge_thr_i),
        .idle_len_i   (idle_len_i),
        .edge_i       (line_edge),
        .level_i      (line_lvl),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .sensor_pwr_o (sensor_pwr_o),
        .frame_done_o (frame_done_o),
        .entry_cnt_o  (entry_cnt_o),
        .state_o      (ctrl_st)
    );

    irc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/irc_capture_chk.sv
module irc_capture_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                det_en_i,
    input logic                cont_mode_i,
    input logic                restart_i,
    input logic                soft_rst_i,
    input logic                rd_en_i,
    input logic                sensor_pwr_o,
    input logic                frame_done_o,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic [ADDR_W:0]     entry_cnt_o,
    input irc_pkg::irc_state_e ctrl_st
);
    localparam int DEPTH = 1 << ADDR_W;

    a_r1_idle_unpowered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !det_en_i |=> (!sensor_pwr_o && !frame_done_o));

    a_r4_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_cnt_o == $past(entry_cnt_o)) ||
        (entry_cnt_o == $past(entry_cnt_o) + (ADDR_W+1)'(1)) ||
        (entry_cnt_o == '0));

    a_r5_done_freezes_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_o && !soft_rst_i) |=> $stable(entry_cnt_o));

    a_r7_cont_keeps_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cont_mode_i && det_en_i && !soft_rst_i && ctrl_st == irc_pkg::ST_ON)
        |=> sensor_pwr_o);

    a_r8_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_cnt_o <= (ADDR_W+1)'(DEPTH));

    a_r9_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

    a_r10_restart_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_i && det_en_i && !soft_rst_i) |=> (sensor_pwr_o && !frame_done_o));

    a_r11_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (entry_cnt_o == '0 && !frame_done_o && !sensor_pwr_o));
endmodule

bind irc_capture_top irc_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .det_en_i     (det_en_i),
    .cont_mode_i  (cont_mode_i),
    .restart_i    (restart_i),
    .soft_rst_i   (soft_rst_i),
    .rd_en_i      (rd_en_i),
    .sensor_pwr_o (sensor_pwr_o),
    .frame_done_o (frame_done_o),
    .rd_data_o    (rd_data_o),
    .entry_cnt_o  (entry_cnt_o),
    .ctrl_st      (ctrl_st)
);

// File: tb/irc_capture_top_tb_top.sv
module irc_capture_top_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        det_en_i = 1'b0;
    logic        cont_mode_i = 1'b0;
    logic        restart_i = 1'b0;
    logic        soft_rst_i = 1'b0;
    logic [11:0] on_len_i = '0;
    logic [16:0] off_len_i = '0;
    logic [6:0]  edge_thr_i = '0;
    logic [14:0] idle_len_i = '0;
    logic        ir_i = 1'b0;
    logic [6:0]  rd_addr_i = '0;
    logic        rd_en_i = 1'b0;
    logic        sensor_pwr_o, frame_done_o;
    logic [15:0] rd_data_o;
    logic [7:0]  entry_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;
    int since = 0;
    bit finished = 0;
    logic [15:0] exp_w [128];
    int n_exp = 0;

    always #4 clk_i = ~clk_i;

    irc_capture_top dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock: tick every fourth clock, optional line toggle
    task automatic step(input bit tog);
        @(negedge clk_i);
        tick_i = (ph == 0);
        if (tog) begin ir_i = ~ir_i; since = 0; end
        else since++;
        ph = (ph + 1) % 4;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step(0);
    endtask

    // edges land in the clock of a tick
    task automatic first_edge();
        while (ph != 2) step(0);
        step(1);
    endtask

    task automatic edge_after(input int k);
        while (since < 4*k - 1) step(0);
        step(1);
    endtask

    task automatic cap_edge(input int k);
        edge_after(k);
        if (n_exp < 128) exp_w[n_exp] = {ir_i, 15'(k)};
        n_exp++;
    endtask

    task automatic read_word(input int a, output logic [15:0] w);
        rd_addr_i = 7'(a);
        rd_en_i = 1'b1;
        step(0);
        w = rd_data_o;
        rd_en_i = 1'b0;
    endtask

    task automatic pulse_restart();
        restart_i = 1'b1;
        step(0);
        restart_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset power", 32'(sensor_pwr_o), 0);
        chk("R1 reset done", 32'(frame_done_o), 0);
        chk("R11 reset count", 32'(entry_cnt_o), 0);
        chk("R9 reset read data", 32'(rd_data_o), 0);
    endtask

    task automatic t_window();
        on_len_i = 12'd5; off_len_i = 17'd10; edge_thr_i = 7'd3; idle_len_i = 15'd6;
        steps(3);
        chk("R1 disabled stays unpowered", 32'(sensor_pwr_o), 0);
        det_en_i = 1'b1;
        steps(3);
        chk("R1 enable powers sensor", 32'(sensor_pwr_o), 1);
        first_edge();
        edge_after(1);
        steps(18);
        chk("R2 failed window sleeps", 32'(sensor_pwr_o), 0);
        steps(20);
        chk("R2 still sleeping", 32'(sensor_pwr_o), 0);
        steps(20);
        chk("R2 new window after sleep", 32'(sensor_pwr_o), 1);
        chk("R2 no capture", 32'(entry_cnt_o), 0);
        det_en_i = 1'b0;
        steps(2);
        chk("R1 disable drops power", 32'(sensor_pwr_o), 0);
        chk("R1 disable no done", 32'(frame_done_o), 0);
    endtask

    task automatic t_capture();
        logic [15:0] w;
        on_len_i = 12'd200; edge_thr_i = 7'd3; idle_len_i = 15'd6;
        n_exp = 0;
        det_en_i = 1'b1;
        steps(2);
        first_edge();
        edge_after(2);
        edge_after(2);
        cap_edge(3);
        cap_edge(5);
        cap_edge(1);
        steps(40);
        chk("R5 frame done", 32'(frame_done_o), 1);
        chk("R5 power off at done", 32'(sensor_pwr_o), 0);
        chk("R4 count after frame", 32'(entry_cnt_o), 3);
        edge_after(2);
        edge_after(2);
        steps(4);
        chk("R5 late edges not counted", 32'(entry_cnt_o), 3);
        for (int a = 0; a < 3; a++) begin
            read_word(a, w);
            chk("R4 stored word", 32'(w), 32'(exp_w[a]));
        end
        read_word(1, w);
        chk("R9 read one clock later", 32'(w), 32'(exp_w[1]));
        rd_addr_i = 7'd0;
        step(0);
        chk("R9 data held without enable", 32'(rd_data_o), 32'(exp_w[1]));
    endtask

    task automatic t_race();
        logic [15:0] w;
        edge_thr_i = 7'd1; idle_len_i = 15'd4;
        n_exp = 0;
        pulse_restart();
        chk("R10 restart clears done", 32'(frame_done_o), 0);
        first_edge();
        cap_edge(3);
        cap_edge(2);
        edge_after(4);
        steps(10);
        chk("R6 frame ends after tie", 32'(frame_done_o), 1);
        chk("R6 tie edge stored, late edge not", 32'(entry_cnt_o), 2);
        read_word(0, w);
        chk("R6 tie word", 32'(w), 32'(exp_w[0]));
        read_word(1, w);
        chk("R6 word after tie", 32'(w), 32'(exp_w[1]));
    endtask

    task automatic t_cont();
        int drops = 0;
        on_len_i = 12'd3; edge_thr_i = 7'd10; cont_mode_i = 1'b1;
        pulse_restart();
        for (int i = 0; i < 80; i++) begin
            if (!sensor_pwr_o) drops++;
            step(0);
        end
        chk("R7 power never drops", 32'(drops), 0);
        cont_mode_i = 1'b0;
        steps(30);
        chk("R7 sleep returns without continuous", 32'(sensor_pwr_o), 0);
    endtask

    task automatic t_full();
        logic [15:0] w;
        on_len_i = 12'd4095; edge_thr_i = 7'd1; idle_len_i = 15'd5;
        n_exp = 0;
        pulse_restart();
        chk("R10 restart keeps count", 32'(entry_cnt_o), 2);
        chk("R10 restart powers", 32'(sensor_pwr_o), 1);
        first_edge();
        steps(3);
        chk("R3 qualification clears count", 32'(entry_cnt_o), 0);
        for (int i = 0; i < 130; i++) cap_edge(2);
        steps(3);
        chk("R8 count capped", 32'(entry_cnt_o), 128);
        chk("R8 still capturing", 32'(frame_done_o), 0);
        steps(40);
        chk("R8 frame ends when full", 32'(frame_done_o), 1);
        read_word(0, w);
        chk("R8 first word", 32'(w), 32'(exp_w[0]));
        read_word(127, w);
        chk("R8 last word", 32'(w), 32'(exp_w[127]));
        pulse_restart();
        chk("R10 done cleared", 32'(frame_done_o), 0);
        chk("R10 count kept", 32'(entry_cnt_o), 128);
    endtask

    task automatic t_soft();
        soft_rst_i = 1'b1; restart_i = 1'b1;
        step(0);
        chk("R11 soft reset count", 32'(entry_cnt_o), 0);
        chk("R11 soft reset beats restart", 32'(sensor_pwr_o), 0);
        chk("R11 soft reset done", 32'(frame_done_o), 0);
        soft_rst_i = 1'b0; restart_i = 1'b0;
        steps(2);
        chk("R11 window after release", 32'(sensor_pwr_o), 1);
    endtask

    initial begin
        steps(4);
        t_reset();
        rst_ni = 1'b1;
        t_window();
        t_capture();
        t_race();
        t_cont();
        t_full();
        t_soft();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule